// File: doc/BRIEF.md
# Debug Command Processor with Read-Clear Status

This block sits behind a serial debug port and handles one 16-bit word per transfer. It decodes two commands. The first writes a control register from an address longword and a data longword. The second reads the debug configuration/status register.

Every transfer returns a 17-bit response: a status flag and 16 data bits. The response to a word is the one presented during the transfer that follows it. That is why the completion code of a command appears while the next command is being shifted in.

The block owns the status register. This holds four sticky event flags and a 4-bit breakpoint trigger-status field. Event inputs and breakpoint-hit inputs stand in for the real comparators. A simple write port stands in for the real control-register file.

Top module: `dbg_cmd_proc`

## Requirements
- R1: After reset the response is the not-ready code (flag 1, data 0x0000), the status register is zero and `wr_en` is low.
- R2: The read command word 0x2D80 returns the 32-bit status register on the next two transfers, upper half first. The word shifted in during the upper-half transfer is ignored. The layout is: bit 31 fault flag, bit 30 trigger flag, bit 29 halt flag, bit 28 breakpoint flag, bits 3:0 trigger status, all other bits zero. The flag is 0 on both data responses.
- R3: A read clears the four sticky flags. The value returned is the one sampled before the clear.
- R4: A read clears the trigger status only in two cases: it holds the level-2 code 0x5, or it holds the level-1 code 0x2 while `bp_l2_armed` is low. Otherwise the field is kept.
- R5: An event that arrives in the same cycle as a read clear wins, so its flag stays set. A level-2 hit wins over a level-1 hit in the same cycle.
- R6: A read word with a nonzero selector (0x2D81 to 0x2D9F), or any other undecoded command word, returns flag 1 with data 0xFFFF. It changes no register state.
- R7: The write command word 0x2880 is followed by four operand words in this order: address upper, address lower, data upper, data lower. The command word and the first three operand words each return not-ready (flag 1, data 0x0000).
- R8: On the last operand word, `wr_en` is high for exactly that transfer cycle, with the assembled `wr_addr` and `wr_data`. Without a bus error the next response is flag 0, data 0xFFFF.
- R9: If `wr_berr` is high during that write, the next response is flag 1, data 0x0001.
- R10: The response changes only on cycles with `xfer_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | One word is transferred this cycle |
| xfer_word | input | 16 | Incoming command or operand word |
| resp_flag | output | 1 | Response status bit (bit 16) |
| resp_data | output | 16 | Response data bits |
| ev_fof | input | 1 | Fault-on-fault event pulse |
| ev_trg | input | 1 | Trigger event pulse |
| ev_halt | input | 1 | Halt event pulse |
| ev_bkpt | input | 1 | Breakpoint event pulse |
| bp_l1_hit | input | 1 | Level-1 breakpoint triggered |
| bp_l2_hit | input | 1 | Level-2 breakpoint triggered |
| bp_l2_armed | input | 1 | Level-2 breakpoint enabled |
| wr_en | output | 1 | Control register write strobe |
| wr_addr | output | 32 | Control register selector |
| wr_data | output | 32 | Control register data |
| wr_berr | input | 1 | Bus error on the current write |

## Verification
The assertions assume two things about the inputs. First, `wr_berr` is meaningful only in the cycle where `wr_en` is high. Second, event and breakpoint inputs are single-cycle pulses that need no handshake. The stimulus keeps to this: `wr_berr` is raised only with the final operand word, and every event is driven for one clock at a falling edge. The only exception is a deliberate overlap with a read command, which tests that the event takes priority over the clear. Transfers are spaced one idle cycle apart. This means the assertion that the response holds still between transfers is exercised on every gap.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int WORD_W  = 16;
  localparam int LONG_W  = 2 * WORD_W;
  localparam int BST_W   = 4;
  localparam int SEL_W   = 5;

  localparam logic [WORD_W-1:0] CMD_RD_BASE = 16'h2D80;
  localparam logic [WORD_W-1:0] CMD_WR      = 16'h2880;

  localparam logic [BST_W-1:0] BST_NONE = 4'h0;
  localparam logic [BST_W-1:0] BST_L1   = 4'h2;
  localparam logic [BST_W-1:0] BST_L2   = 4'h5;

  typedef struct packed {
    logic              flag;
    logic [WORD_W-1:0] data;
  } resp_t;

  localparam resp_t RSP_NOT_READY = '{flag: 1'b1, data: 16'h0000};
  localparam resp_t RSP_ILLEGAL   = '{flag: 1'b1, data: 16'hFFFF};
  localparam resp_t RSP_DONE      = '{flag: 1'b0, data: 16'hFFFF};
  localparam resp_t RSP_BUS_ERR   = '{flag: 1'b1, data: 16'h0001};

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_W_AH, ST_W_AL, ST_W_DH, ST_W_DL
  } seq_state_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic              is_rd_csr,
  output logic              is_wr
);
  localparam int OP_W = WORD_W - SEL_W;

  logic op_match;

  always_comb begin
    op_match  = (word[WORD_W-1:SEL_W] == CMD_RD_BASE[WORD_W-1:SEL_W]);
    is_rd_csr = op_match && (word[SEL_W-1:0] == '0);
    is_wr     = (word == CMD_WR);
  end
endmodule

// File: rtl/dbg_csr.sv
module dbg_csr
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic [3:0]        ev_set,
  input  logic              l1_hit,
  input  logic              l2_hit,
  input  logic              l2_armed,
  input  logic              rd_clr,
  output logic [3:0]        flags_q,
  output logic [BST_W-1:0]  bstat_q,
  output logic [LONG_W-1:0] csr_word
);
  localparam int PAD_W = LONG_W - 4 - BST_W;

  logic [3:0]       flags_d;
  logic [BST_W-1:0] bstat_d;
  logic             bst_clr_ok;

  always_comb begin
    bst_clr_ok = (bstat_q == BST_L2) || ((bstat_q == BST_L1) && !l2_armed);
    flags_d    = rd_clr ? 4'b0000 : flags_q;
    flags_d    = flags_d | ev_set;
    bstat_d    = bstat_q;
    if (rd_clr && bst_clr_ok) bstat_d = BST_NONE;
    if (l2_hit)      bstat_d = BST_L2;
    else if (l1_hit) bstat_d = BST_L1;
    csr_word   = {flags_q, {PAD_W{1'b0}}, bstat_q};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      flags_q <= '0;
      bstat_q <= BST_NONE;
    end else begin
      flags_q <= flags_d;
      bstat_q <= bstat_d;
    end
  end
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              xfer_valid,
  input  logic [WORD_W-1:0] xfer_word,
  input  logic              is_rd_csr,
  input  logic              is_wr,
  input  logic [LONG_W-1:0] csr_word,
  input  logic              wr_berr,
  output logic              rd_clr,
  output logic              wr_en,
  output logic [LONG_W-1:0] wr_addr,
  output logic [LONG_W-1:0] wr_data,
  output resp_t             resp_q,
  output seq_state_t        state_q
);
  seq_state_t        state_d;
  resp_t             resp_d;
  logic [LONG_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] dhi_q, dhi_d;
  logic [WORD_W-1:0] shadow_q, shadow_d;

  always_comb begin
    state_d  = state_q;
    resp_d   = resp_q;
    addr_d   = addr_q;
    dhi_d    = dhi_q;
    shadow_d = shadow_q;
    rd_clr   = 1'b0;
    wr_en    = 1'b0;
    if (xfer_valid) begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_rd_csr) begin
            rd_clr   = 1'b1;
            resp_d   = '{flag: 1'b0, data: csr_word[LONG_W-1:WORD_W]};
            shadow_d = csr_word[WORD_W-1:0];
            state_d  = ST_RD_LO;
          end else if (is_wr) begin
            resp_d  = RSP_NOT_READY;
            state_d = ST_W_AH;
          end else begin
            resp_d  = RSP_ILLEGAL;
          end
        end
        ST_RD_LO: begin
          resp_d  = '{flag: 1'b0, data: shadow_q};
          state_d = ST_IDLE;
        end
        ST_W_AH: begin
          addr_d[LONG_W-1:WORD_W] = xfer_word;
          resp_d  = RSP_NOT_READY;
          state_d = ST_W_AL;
        end
        ST_W_AL: begin
          addr_d[WORD_W-1:0] = xfer_word;
          resp_d  = RSP_NOT_READY;
          state_d = ST_W_DH;
        end
        ST_W_DH: begin
          dhi_d   = xfer_word;
          resp_d  = RSP_NOT_READY;
          state_d = ST_W_DL;
        end
        ST_W_DL: begin
          wr_en   = 1'b1;
          resp_d  = wr_berr ? RSP_BUS_ERR : RSP_DONE;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
    wr_addr = addr_q;
    wr_data = {dhi_q, xfer_word};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= ST_IDLE;
      resp_q   <= RSP_NOT_READY;
      addr_q   <= '0;
      dhi_q    <= '0;
      shadow_q <= '0;
    end else if (xfer_valid) begin
      state_q  <= state_d;
      resp_q   <= resp_d;
      addr_q   <= addr_d;
      dhi_q    <= dhi_d;
      shadow_q <= shadow_d;
    end
  end
endmodule

// File: rtl/dbg_cmd_proc.sv
module dbg_cmd_proc
  import dbg_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_valid,
  input  logic [15:0] xfer_word,
  output logic        resp_flag,
  output logic [15:0] resp_data,
  input  logic        ev_fof,
  input  logic        ev_trg,
  input  logic        ev_halt,
  input  logic        ev_bkpt,
  input  logic        bp_l1_hit,
  input  logic        bp_l2_hit,
  input  logic        bp_l2_armed,
  output logic        wr_en,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  input  logic        wr_berr
);
  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic              is_rd_csr, is_wr, rd_clr;
  logic [3:0]        flags_q;
  logic [BST_W-1:0]  bstat_q;
  logic [LONG_W-1:0] csr_word;
  resp_t             resp_q;
  seq_state_t        state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  dbg_cmd_decode u_dec (
    .word      (xfer_word),
    .is_rd_csr (is_rd_csr),
    .is_wr     (is_wr)
  );

  dbg_csr u_csr (
    .clk      (clk),
    .rst_sn   (rst_sn),
    .ev_set   ({ev_fof, ev_trg, ev_halt, ev_bkpt}),
    .l1_hit   (bp_l1_hit),
    .l2_hit   (bp_l2_hit),
    .l2_armed (bp_l2_armed),
    .rd_clr   (rd_clr),
    .flags_q  (flags_q),
    .bstat_q  (bstat_q),
    .csr_word (csr_word)
  );

  dbg_cmd_seq u_seq (
    .clk        (clk),
    .rst_sn     (rst_sn),
    .xfer_valid (xfer_valid),
    .xfer_word  (xfer_word),
    .is_rd_csr  (is_rd_csr),
    .is_wr      (is_wr),
    .csr_word   (csr_word),
    .wr_berr    (wr_berr),
    .rd_clr     (rd_clr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .resp_q     (resp_q),
    .state_q    (state_q)
  );

  assign resp_flag = resp_q.flag;
  assign resp_data = resp_q.data;
endmodule

// File: rtl/dbg_cmd_proc_chk.sv
module dbg_cmd_proc_chk
  import dbg_cmd_pkg::*;
(
  input logic        clk,
  input logic        rst_sn,
  input logic        xfer_valid,
  input logic [15:0] xfer_word,
  input logic        resp_flag,
  input logic [15:0] resp_data,
  input logic [3:0]  flags_q,
  input logic [3:0]  ev_any,
  input logic        wr_en,
  input logic        wr_berr,
  input seq_state_t  state_q
);
  logic idle_cmd_rd, idle_cmd_wr, idle_cmd_bad;
  always_comb begin
    idle_cmd_rd  = xfer_valid && (state_q == ST_IDLE) && (xfer_word == 16'h2D80);
    idle_cmd_wr  = xfer_valid && (state_q == ST_IDLE) && (xfer_word == 16'h2880);
    idle_cmd_bad = xfer_valid && (state_q == ST_IDLE) && !idle_cmd_rd && !idle_cmd_wr;
  end

  assert_illegal_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    idle_cmd_bad |=> (resp_flag && resp_data == 16'hFFFF));

  assert_rd_clear_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle_cmd_rd && ev_any == 4'b0000) |=> (flags_q == 4'b0000));

  assert_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle_cmd_wr || (xfer_valid && (state_q == ST_W_AH || state_q == ST_W_AL ||
                                    state_q == ST_W_DH)))
    |=> (resp_flag && resp_data == 16'h0000));

  assert_wr_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en |-> xfer_valid);

  assert_wr_done_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && !wr_berr) |=> (!resp_flag && resp_data == 16'hFFFF));

  assert_wr_berr_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en && wr_berr) |=> (resp_flag && resp_data == 16'h0001));

  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !xfer_valid |=> $stable({resp_flag, resp_data}));
endmodule

bind dbg_cmd_proc dbg_cmd_proc_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .xfer_valid (xfer_valid),
  .xfer_word  (xfer_word),
  .resp_flag  (resp_flag),
  .resp_data  (resp_data),
  .flags_q    (flags_q),
  .ev_any     ({ev_fof, ev_trg, ev_halt, ev_bkpt}),
  .wr_en      (wr_en),
  .wr_berr    (wr_berr),
  .state_q    (state_q)
);

// File: tb/dbg_cmd_proc_test.sv
module dbg_cmd_proc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0;
  logic [15:0] xfer_word = '0;
  logic        resp_flag;
  logic [15:0] resp_data;
  logic        ev_fof = 0, ev_trg = 0, ev_halt = 0, ev_bkpt = 0;
  logic        bp_l1_hit = 0, bp_l2_hit = 0, bp_l2_armed = 0;
  logic        wr_en;
  logic [31:0] wr_addr, wr_data;
  logic        wr_berr = 1'b0;

  int total = 0;
  int bad = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] exp_addr, exp_data;
  logic [16:0] last_exp;

  always #4 clk = ~clk;

  dbg_cmd_proc uut (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_word(xfer_word),
    .resp_flag(resp_flag), .resp_data(resp_data),
    .ev_fof(ev_fof), .ev_trg(ev_trg), .ev_halt(ev_halt), .ev_bkpt(ev_bkpt),
    .bp_l1_hit(bp_l1_hit), .bp_l2_hit(bp_l2_hit), .bp_l2_armed(bp_l2_armed),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_berr(wr_berr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected response for each transfer
  always @(posedge clk) begin
    if (xfer_valid) begin
      #2;
      if (exp_q.size() == 0) check("R10 unexpected transfer", 1, 0);
      else check(tag_q.pop_front(), {resp_flag, resp_data}, exp_q.pop_front());
    end
  end

  task automatic send(input logic [15:0] w, input logic [16:0] exp, input logic berr,
                      input logic expw, input string tag);
    @(negedge clk);
    xfer_valid = 1'b1;
    xfer_word  = w;
    wr_berr    = berr;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    last_exp = exp;
    #1;
    check({tag, " wr_en"}, wr_en, expw);
    if (expw) begin
      check("R8 wr_addr", wr_addr, exp_addr);
      check("R8 wr_data", wr_data, exp_data);
    end
    @(negedge clk);
    xfer_valid = 1'b0;
    wr_berr    = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] ev, input logic l1, input logic l2);
    @(negedge clk);
    {ev_fof, ev_trg, ev_halt, ev_bkpt} = ev;
    bp_l1_hit = l1;
    bp_l2_hit = l2;
    @(negedge clk);
    {ev_fof, ev_trg, ev_halt, ev_bkpt} = 4'b0;
    bp_l1_hit = 1'b0;
    bp_l2_hit = 1'b0;
  endtask

  task automatic rd(input logic [15:0] hi, input logic [15:0] lo, input string tag);
    send(16'h2D80, {1'b0, hi}, 1'b0, 1'b0, {tag, " upper"});
    send(16'h0000, {1'b0, lo}, 1'b0, 1'b0, {tag, " lower"});
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic berr,
                    input logic [16:0] fin, input string tag);
    exp_addr = a;
    exp_data = d;
    send(16'h2880,  17'h10000, 1'b0, 1'b0, "R7 cmd not-ready");
    send(a[31:16],  17'h10000, 1'b0, 1'b0, "R7 addr hi not-ready");
    send(a[15:0],   17'h10000, 1'b0, 1'b0, "R7 addr lo not-ready");
    send(d[31:16],  17'h10000, 1'b0, 1'b0, "R7 data hi not-ready");
    send(d[15:0],   fin,       berr, 1'b1, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 reset response", {resp_flag, resp_data}, 17'h10000);
    check("R1 reset wr_en", wr_en, 0);

    rd(16'h0000, 16'h0000, "R1 csr zero");

    // flags and level-1 status, level-2 not armed: all cleared by read
    pulse(4'b1010, 1'b1, 1'b0);
    rd(16'hA000, 16'h0002, "R2 R3 snapshot");
    rd(16'h0000, 16'h0000, "R3 R4 cleared l1 unarmed");

    // level-1 with level-2 armed: status kept
    bp_l2_armed = 1'b1;
    pulse(4'b0000, 1'b1, 1'b0);
    rd(16'h0000, 16'h0002, "R4 l1 armed first");
    rd(16'h0000, 16'h0002, "R4 l1 armed kept");
    pulse(4'b0000, 1'b0, 1'b1);
    rd(16'h0000, 16'h0005, "R4 l2 snapshot");
    rd(16'h0000, 16'h0000, "R4 l2 cleared");
    bp_l2_armed = 1'b0;

    // level-2 wins over level-1
    pulse(4'b0000, 1'b1, 1'b1);
    rd(16'h0000, 16'h0005, "R5 l2 over l1");
    rd(16'h0000, 16'h0000, "R4 l2 cleared again");

    pulse(4'b0101, 1'b0, 1'b0);
    rd(16'h5000, 16'h0000, "R2 trg bkpt");

    // illegal words leave state alone
    pulse(4'b0010, 1'b0, 1'b0);
    send(16'h2D81, 17'h1FFFF, 1'b0, 1'b0, "R6 reserved selector");
    send(16'h2D9F, 17'h1FFFF, 1'b0, 1'b0, "R6 reserved top selector");
    send(16'h1234, 17'h1FFFF, 1'b0, 1'b0, "R6 undecoded word");
    rd(16'h2000, 16'h0000, "R6 state unchanged");

    // event during clear wins
    @(negedge clk);
    ev_halt = 1'b1;
    send(16'h2D80, 17'h02000, 1'b0, 1'b0, "R5 overlap upper");
    ev_halt = 1'b0;
    send(16'h0000, 17'h00000, 1'b0, 1'b0, "R5 overlap lower");
    rd(16'h2000, 16'h0000, "R5 event kept");
    rd(16'h0000, 16'h0000, "R5 now cleared");

    // writes
    wr(32'h12345678, 32'h9ABCDEF0, 1'b0, 17'h0FFFF, "R8 write done");
    rd(16'h0000, 16'h0000, "R8 next cmd after write");
    wr(32'h00000C04, 32'hFFFF0001, 1'b1, 17'h10001, "R9 bus error");
    send(16'h0BAD, 17'h1FFFF, 1'b0, 1'b0, "R6 illegal after write");

    // response holds without transfers
    repeat (5) @(negedge clk);
    #1;
    check("R10 response held", {resp_flag, resp_data}, last_exp);
    check("R8 no strobe idle", wr_en, 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule